// File: doc/BRIEF.md
# Handle-Keyed Hash Table Engine

This block owns a table of context-object slots held in a single-port on-chip RAM. A requester hands it one command at a time, keyed by a 32-bit handle and a 4-bit channel number. The command is a lookup, an insert or a remove. The engine folds the handle, and in legacy mode the channel, into a start slot. From there it steps through the table one slot at a time with wrap-around. It stops when it finds what the command needs or when it arrives back at the start slot.

Each slot keeps a handle word and a context word. An insert places the pair in the first slot that counts as free. A lookup returns the context word of the first occupied slot whose handle matches. A remove clears the first such slot. The requester builds the context word; the engine only stores it and compares handles. A mode input picks one of two rules. In legacy mode a slot is occupied when bit 31 of its context word is set, and the channel is mixed into the hash. In the newer mode a slot is occupied when its context word is nonzero, and the channel is ignored.

Top module: `htab_engine`

## Requirements
- R1: After reset the engine clears every slot: cmd_ready stays low for exactly 2^IDX_W cycles after reset is released, then goes high, and a lookup then misses.
- R2: The start slot is the XOR of the IDX_W-bit chunks of the handle, taken from the least significant bit upward. The top chunk is zero-padded.
- R3: With mode_legacy = 1, the channel shifted left by IDX_W-4 is XOR-ed into the start slot. With mode_legacy = 0 the channel has no effect.
- R4: A probe that does not finish the command moves to the next slot. It wraps from the last slot to slot 0, and the search fails once the next slot would be the start slot.
- R5: A slot counts as occupied when context bit 31 is set (mode_legacy = 1) or when the context word is nonzero (mode_legacy = 0).
- R6: Insert (cmd_op = 1) writes the handle and context into the first unoccupied slot and reports rsp_found = 1, rsp_full = 0, rsp_ctx = 0.
- R7: An insert that finds no free slot reports rsp_full = 1, rsp_found = 0, and leaves the table unchanged.
- R8: Lookup (cmd_op = 0) reports rsp_found = 1 and the stored context on a hit. On a miss it reports rsp_found = 0, rsp_ctx = 0 after a full wrap.
- R9: Remove (cmd_op = 2) clears both words of the first matching occupied slot and reports rsp_found = 1 with the removed context. Without a match it reports rsp_found = 0.
- R10: When a command ends at its k-th probe, the response arrives 2k+1 cycles after acceptance for a lookup, or 2k+2 cycles for a successful insert or remove. A miss or a full table takes 2*2^IDX_W+1 cycles.
- R11: cmd_ready is high only while the engine is idle and drops the cycle after a command is accepted. rsp_valid is a one-cycle pulse, and the engine is ready again in the cycle that follows it.
- R12: Opcode 3 is reserved. It responds in the cycle right after acceptance with rsp_found = 0, rsp_full = 0, rsp_ctx = 0, and it changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_legacy | input | 1 | 1: bit-31 occupancy and channel hashing; 0: nonzero occupancy, no channel |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | 0 lookup, 1 insert, 2 remove, 3 reserved |
| cmd_handle | input | 32 | Object handle key |
| cmd_chan | input | 4 | Channel number |
| cmd_ctx | input | 32 | Context word to store on insert |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_found | output | 1 | Hit (lookup/remove) or stored (insert) |
| rsp_full | output | 1 | Insert failed, no free slot |
| rsp_ctx | output | 32 | Context read back on a lookup or remove hit |

## Verification
A wrong start slot or probe step does not corrupt the results returned right away. It shows up as a changed response latency, because every probe costs two cycles. The bench therefore compares the latency of every command with the probe count of a reference model, and a bad hash shows on the first command after it. A wrong occupancy rule or a stale slot shows on the next command that reaches that slot: it returns a wrong hit, a wrong context word or a wrong full status. A clear sweep that runs too short or too long shows in the number of cycles before the engine becomes ready after reset.

// File: rtl/htab_pkg.sv
package htab_pkg;
    localparam int HANDLE_W = 32;
    localparam int CTX_W    = 32;
    localparam int CH_W     = 4;
    localparam int SLOT_W   = HANDLE_W + CTX_W;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_REMOVE = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_HASH,
        ST_READ,
        ST_CMP,
        ST_WRITE,
        ST_DONE
    } state_e;

    function automatic logic slot_busy(input logic [CTX_W-1:0] ctx, input logic legacy);
        return legacy ? ctx[CTX_W-1] : (ctx != '0);
    endfunction
endpackage

// File: rtl/htab_hash.sv
module htab_hash
    import htab_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic [HANDLE_W-1:0] handle,
    input  logic [CH_W-1:0]     chan,
    input  logic                mix_chan,
    output logic [IDX_W-1:0]    idx
);
    localparam int NCHUNK = (HANDLE_W + IDX_W - 1) / IDX_W;

    logic [IDX_W-1:0] part [NCHUNK];

    genvar g;
    generate
        for (g = 0; g < NCHUNK; g++) begin : g_chunk
            assign part[g] = IDX_W'(handle >> (g * IDX_W));
        end
    endgenerate

    always_comb begin
        logic [IDX_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            acc = acc ^ part[i];
        end
        if (mix_chan) begin
            acc = acc ^ IDX_W'(32'(chan) << (IDX_W - CH_W));
        end
        idx = acc;
    end
endmodule

// File: rtl/htab_ram.sv
module htab_ram #(
    parameter int AW = 9,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/htab_engine.sv
module htab_engine
    import htab_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_legacy,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [HANDLE_W-1:0] cmd_handle,
    input  logic [CH_W-1:0]     cmd_chan,
    input  logic [CTX_W-1:0]    cmd_ctx,
    output logic                rsp_valid,
    output logic                rsp_found,
    output logic                rsp_full,
    output logic [CTX_W-1:0]    rsp_ctx
);
    localparam int SLOTS = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    typedef struct packed {
        state_e              st;
        op_e                 op;
        logic [HANDLE_W-1:0] handle;
        logic [CH_W-1:0]     chan;
        logic [CTX_W-1:0]    ctx;
        logic                legacy;
        logic [IDX_W-1:0]    start;
        logic [IDX_W-1:0]    probe;
        logic [SLOT_W-1:0]   wr_slot;
        logic                found;
        logic                full;
        logic [CTX_W-1:0]    rd_ctx;
    } regs_t;

    regs_t r_d, r_q;

    logic              ram_en, ram_we;
    logic [IDX_W-1:0]  ram_addr;
    logic [SLOT_W-1:0] ram_wdata, ram_rdata;
    logic [IDX_W-1:0]  hash_idx;

    htab_hash #(.IDX_W(IDX_W)) u_hash (
        .handle   (r_q.handle),
        .chan     (r_q.chan),
        .mix_chan (r_q.legacy),
        .idx      (hash_idx)
    );

    htab_ram #(.AW(IDX_W), .DW(SLOT_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        logic [HANDLE_W-1:0] rd_handle;
        logic [CTX_W-1:0]    rd_ctx;
        logic                busy, hit, advance;
        logic [IDX_W-1:0]    nxt;

        r_d       = r_q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = r_q.probe;
        ram_wdata = r_q.wr_slot;
        rd_handle = ram_rdata[SLOT_W-1 -: HANDLE_W];
        rd_ctx    = ram_rdata[CTX_W-1:0];
        busy      = slot_busy(rd_ctx, r_q.legacy);
        hit       = busy && (rd_handle == r_q.handle);
        advance   = 1'b0;
        nxt       = r_q.probe + IDX_W'(1);

        case (r_q.st)
            ST_CLEAR: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_wdata = '0;
                r_d.probe = nxt;
                if (r_q.probe == LAST) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.op     = op_e'(cmd_op);
                    r_d.handle = cmd_handle;
                    r_d.chan   = cmd_chan;
                    r_d.ctx    = cmd_ctx;
                    r_d.legacy = mode_legacy;
                    r_d.found  = 1'b0;
                    r_d.full   = 1'b0;
                    r_d.rd_ctx = '0;
                    r_d.st     = (op_e'(cmd_op) == OP_RSVD) ? ST_DONE : ST_HASH;
                end
            end
            ST_HASH: begin
                r_d.start = hash_idx;
                r_d.probe = hash_idx;
                r_d.st    = ST_READ;
            end
            ST_READ: begin
                ram_en = 1'b1;
                r_d.st = ST_CMP;
            end
            ST_CMP: begin
                case (r_q.op)
                    OP_INSERT: begin
                        if (!busy) begin
                            r_d.wr_slot = {r_q.handle, r_q.ctx};
                            r_d.found   = 1'b1;
                            r_d.st      = ST_WRITE;
                        end else begin
                            advance = 1'b1;
                        end
                    end
                    OP_LOOKUP: begin
                        if (hit) begin
                            r_d.found  = 1'b1;
                            r_d.rd_ctx = rd_ctx;
                            r_d.st     = ST_DONE;
                        end else begin
                            advance = 1'b1;
                        end
                    end
                    OP_REMOVE: begin
                        if (hit) begin
                            r_d.wr_slot = '0;
                            r_d.found   = 1'b1;
                            r_d.rd_ctx  = rd_ctx;
                            r_d.st      = ST_WRITE;
                        end else begin
                            advance = 1'b1;
                        end
                    end
                    default: r_d.st = ST_DONE;
                endcase
                if (advance) begin
                    if (nxt == r_q.start) begin
                        r_d.full = (r_q.op == OP_INSERT);
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.probe = nxt;
                        r_d.st    = ST_READ;
                    end
                end
            end
            ST_WRITE: begin
                ram_en = 1'b1;
                ram_we = 1'b1;
                r_d.st = ST_DONE;
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_CLEAR;
            r_q.op    <= OP_LOOKUP;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = (r_q.st == ST_DONE);
    assign rsp_found = r_q.found;
    assign rsp_full  = r_q.full;
    assign rsp_ctx   = r_q.rd_ctx;

    // R11: result strobe lasts a single cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: acceptance makes the engine busy on the next cycle
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R11: engine returns to idle right after the strobe
    a_r11_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> cmd_ready);

    // R7: a full report never claims a stored entry
    a_r7_full_not_found: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_full) |-> !rsp_found);

    // R6: a command-driven table write is followed by the response
    a_r6_write_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && r_q.st != ST_CLEAR) |=> (rsp_valid && rsp_found));

    // R12: reserved opcode answers in the next cycle
    a_r12_reserved_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> (rsp_valid && !rsp_found && !rsp_full));
endmodule

// File: tb/htab_engine_bench.sv
module htab_engine_bench;
    localparam int B = 5;
    localparam int N = 1 << B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_legacy = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_handle = '0;
    logic [3:0]  cmd_chan = '0;
    logic [31:0] cmd_ctx = '0;
    logic        rsp_valid, rsp_found, rsp_full;
    logic [31:0] rsp_ctx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_h [N];
    logic [31:0] m_c [N];

    always #4 clk = ~clk;

    htab_engine #(.IDX_W(B)) u_htab_engine (
        .clk(clk), .rst_n(rst_n), .mode_legacy(mode_legacy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_handle(cmd_handle), .cmd_chan(cmd_chan), .cmd_ctx(cmd_ctx),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_full(rsp_full),
        .rsp_ctx(rsp_ctx)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int ref_start(input logic [31:0] h, input logic [3:0] ch, input logic leg);
        int s = 0;
        for (int i = 0; i < 32; i += B) s ^= int'((h >> i) & (N - 1));
        if (leg) s ^= (int'(ch) << (B - 4)) & (N - 1);
        return s;
    endfunction

    function automatic bit ref_busy(input logic [31:0] c, input logic leg);
        return leg ? c[31] : (c != 0);
    endfunction

    // reference model: computes the expected result and updates the table copy
    task automatic ref_exec(input int op, input logic [31:0] h, input logic [3:0] ch,
                            input logic [31:0] c, input logic leg,
                            output bit f, output bit full, output logic [31:0] rc, output int lat);
        int s0 = ref_start(h, ch, leg);
        f = 0; full = 0; rc = 0; lat = 2 * N + 1;
        if (op == 3) begin lat = 0; return; end
        for (int k = 0; k < N; k++) begin
            int s = (s0 + k) % N;
            if (op == 1 && !ref_busy(m_c[s], leg)) begin
                m_h[s] = h; m_c[s] = c; f = 1; lat = 2 * (k + 1) + 2; return;
            end
            if (op != 1 && ref_busy(m_c[s], leg) && m_h[s] == h) begin
                f = 1; rc = m_c[s];
                if (op == 2) begin m_h[s] = 0; m_c[s] = 0; lat = 2 * (k + 1) + 2; end
                else lat = 2 * (k + 1) + 1;
                return;
            end
        end
        full = (op == 1);
    endtask

    task automatic run_cmd(input string tag, input int op, input logic [31:0] h,
                           input logic [3:0] ch, input logic [31:0] c);
        bit ef, efull; logic [31:0] ectx; int elat; int cnt = 0;
        ref_exec(op, h, ch, c, mode_legacy, ef, efull, ectx, elat);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); cmd_handle = h; cmd_chan = ch; cmd_ctx = c;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        chk("R11", "ready after accept", cmd_ready, 0);
        while (!rsp_valid && cnt < 5000) begin @(posedge clk); @(negedge clk); cnt++; end
        chk(tag, "found", rsp_found, ef);
        chk(tag, "full", rsp_full, efull);
        chk(tag, "ctx", rsp_ctx, ectx);
        chk("R10", "latency", cnt, elat);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "pulse end", rsp_valid, 0);
        chk("R11", "ready again", cmd_ready, 1);
    endtask

    task automatic do_reset(input logic leg);
        int cnt = 0;
        @(negedge clk);
        rst_n = 0; mode_legacy = leg;
        for (int i = 0; i < N; i++) begin m_h[i] = 0; m_c[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", cmd_ready, 0);
        chk("R11", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1;
        while (!cmd_ready && cnt < 1000) begin @(posedge clk); @(negedge clk); cnt++; end
        chk("R1", "clear sweep cycles", cnt, N);
    endtask

    task automatic t_reset_empty();
        do_reset(0);
        run_cmd("R1", 0, 32'h0000_0042, 4'd0, 0);
        run_cmd("R8", 0, 32'h0000_0000, 4'd0, 0);
    endtask

    task automatic t_basic();
        run_cmd("R6", 1, 32'h0000_0003, 4'd0, 32'h0000_1111);
        run_cmd("R6", 1, 32'hDEAD_BEEF, 4'd2, 32'h0000_2222);
        run_cmd("R2", 1, 32'h1357_9BDF, 4'd0, 32'h0000_3333);
        run_cmd("R8", 0, 32'hDEAD_BEEF, 4'd0, 0);
        run_cmd("R8", 0, 32'h1357_9BDF, 4'd0, 0);
        run_cmd("R3", 0, 32'h0000_0003, 4'd9, 0);
    endtask

    task automatic t_collide();
        run_cmd("R4", 1, 32'h0000_0022, 4'd0, 32'h0000_4444);
        run_cmd("R4", 0, 32'h0000_0022, 4'd0, 0);
        run_cmd("R4", 1, 32'h0000_001F, 4'd0, 32'h0000_5555);
        run_cmd("R4", 1, 32'h0000_003E, 4'd0, 32'h0000_6666);
        run_cmd("R4", 0, 32'h0000_003E, 4'd0, 0);
    endtask

    task automatic t_remove();
        run_cmd("R9", 2, 32'h0000_0003, 4'd0, 0);
        run_cmd("R9", 0, 32'h0000_0003, 4'd0, 0);
        run_cmd("R9", 0, 32'h0000_0022, 4'd0, 0);
        run_cmd("R9", 2, 32'h0000_0777, 4'd0, 0);
        run_cmd("R6", 1, 32'h0000_0003, 4'd0, 32'h0000_7777);
        run_cmd("R8", 0, 32'h0000_0003, 4'd0, 0);
    endtask

    task automatic t_reserved();
        run_cmd("R12", 3, 32'hDEAD_BEEF, 4'd0, 32'hFFFF_FFFF);
        run_cmd("R12", 0, 32'hDEAD_BEEF, 4'd0, 0);
    endtask

    task automatic t_legacy();
        do_reset(1);
        run_cmd("R5", 1, 32'h0000_1234, 4'd0, 32'h0000_00AA);
        run_cmd("R5", 0, 32'h0000_1234, 4'd0, 0);
        run_cmd("R5", 1, 32'h0000_1234, 4'd0, 32'h8000_0001);
        run_cmd("R3", 1, 32'h0000_1234, 4'd3, 32'h8000_0003);
        run_cmd("R3", 0, 32'h0000_1234, 4'd3, 0);
        run_cmd("R3", 0, 32'h0000_1234, 4'd0, 0);
        run_cmd("R9", 2, 32'h0000_1234, 4'd3, 0);
        run_cmd("R9", 0, 32'h0000_1234, 4'd3, 0);
    endtask

    task automatic t_full();
        do_reset(0);
        for (int i = 0; i < N; i++) begin
            run_cmd("R6", 1, 32'(i * 7 + 100), 4'd0, 32'(i + 1));
        end
        run_cmd("R7", 1, 32'h0BAD_0001, 4'd0, 32'h0000_0099);
        run_cmd("R7", 0, 32'h0BAD_0001, 4'd0, 0);
        run_cmd("R8", 0, 32'(5 * 7 + 100), 4'd0, 0);
    endtask

    initial begin
        t_reset_empty();
        t_basic();
        t_collide();
        t_remove();
        t_reserved();
        t_legacy();
        t_full();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule